// File: doc/BRIEF.md
# Chained-Segment Command Fetcher

This block serves one command queue held in memory as a chain of segments. Software adds to a doorbell the number of 64-bit words it has written. The block then reads 8-word commands one at a time and streams them out. Each segment holds `8n+1` words: `n` commands followed by one link word, which gives the address of the next segment. The block tracks how many commands are in flight between fetch and completion, and it stops fetching on an error unless continue-on-error is set.

Configuration arrives on a plain one-cycle write port. Memory reads leave on a request stream and return on a response stream. Commands leave on a valid/ready word stream. All three streams follow the same rules: once valid is raised, the payload holds until ready is seen high at a clock edge. Back-pressure on the command stream stalls the response stream (`rd_rsp_ready` follows `cmd_ready` during a command). Link-word responses are always accepted. Only one read is outstanding at a time.

Top module: `iq_fetch_top`

## Requirements
- R1: A write with select 0 adds `cfg_wr_data[19:0]` to the 20-bit pending word count shown on `dbell_pending`. The count drops by 8 in the cycle a command read request is accepted.
- R2: When a doorbell add carries out of 20 bits, the count keeps the low 20 bits and error flag bit 2 is set.
- R3: A command read request (`rd_req_link`=0) is raised only while the queue is enabled, at least 8 words are pending and the in-flight count is below `MAX_INFLIGHT`. Its byte address is the segment base plus 64 times the command index. `rd_req_valid`, `rd_req_addr` and `rd_req_link` hold until the request is accepted.
- R4: The 8 response beats of a command are forwarded in order on `cmd_data`, with `cmd_last` set on the eighth beat. `cmd_ready` low stalls the response stream.
- R5: Each segment holds `n = size[12:3]` commands. After `n` commands, and once at least 8 words are pending while the queue is enabled, the link word at base + 64·n is read (`rd_req_link`=1). Its bits 48:6 become the new base and the command index resets to 0. `fetch_addr` always shows base + 64·index.
- R6: `inflight` rises by 1 when a command request is accepted and falls by 1 on `done_pulse`. It is unchanged when both happen in the same cycle, never goes below zero and never exceeds `MAX_INFLIGHT`.
- R7: Writes to the start address (select 1, byte address, bits 48:6 used) and to the segment size (select 2, bits 12:0) take effect only when the queue is disabled, `inflight` is zero and no read is outstanding. Otherwise they are ignored.
- R8: Error flag bit 0 records a response beat with `rd_rsp_err`. Bit 1 records `res_wr_err`. Bit 2 records a doorbell overflow. When continue-on-error is 0, any of these events clears the enable. When it is 1, the enable stays set.
- R9: The control write (select 3) sets the enable from bit 0 and continue-on-error from bit 1. Select 4 clears error flags where data bits are 1. Select 5 sets interrupt enables where data bits are 1. `irq` is the OR over all sources of flag AND enable.
- R10: After reset the pending count, in-flight count, enable, flags, interrupt enables, `irq`, `fetch_addr` and all stream valids are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Register select (0 doorbell, 1 start, 2 size, 3 control, 4 flag clear, 5 irq enable set) |
| cfg_wr_data | input | 49 | Write data |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 49 | Read byte address, 64-byte aligned |
| rd_req_link | output | 1 | 1: single link word, 0: 8-word command |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_ready | output | 1 | Response beat accepted |
| rd_rsp_data | input | 64 | Response word |
| rd_rsp_err | input | 1 | Response beat carries a read error |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Command word accepted |
| cmd_data | output | 64 | Command word |
| cmd_last | output | 1 | Eighth word of a command |
| done_pulse | input | 1 | One command completed |
| res_wr_err | input | 1 | Result write error reported downstream |
| q_enable | output | 1 | Queue enable state |
| dbell_pending | output | 20 | Pending doorbell words |
| fetch_addr | output | 49 | Next fetch byte address |
| inflight | output | 8 | Commands in flight |
| err_flags | output | 3 | Sticky error flags |
| irq | output | 1 | Interrupt |

## Verification
The main function is tried with several doorbell patterns. A short ring stays inside one segment. A longer ring crosses two link words and then wraps the chain back to its first segment, which separates correct link following from plain address increment. A ring made while the in-flight limit is reached shows that the link read still goes ahead while the next command waits for a completion. Errors are injected with continue-on-error both clear and set, and on a command read response, to tell enable clearing apart from flag recording. Configuration writes are made both while enabled and while quiescent, to show the gate at work.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int ADDR_W    = 49;
  localparam int LINE_LSB  = 6;
  localparam int PTR_W     = ADDR_W - LINE_LSB;
  localparam int DATA_W    = 64;
  localparam int CMD_BEATS = 8;
  localparam int BEAT_W    = $clog2(CMD_BEATS);
  localparam int SEG_W     = 13;
  localparam int IDX_W     = SEG_W - BEAT_W;
  localparam int DB_W      = 20;
  localparam int INFL_W    = 8;
  localparam int NERR      = 3;
  localparam int ERR_RD    = 0;
  localparam int ERR_WR    = 1;
  localparam int ERR_DOVF  = 2;

  typedef enum logic [2:0] {
    SEL_DBELL  = 3'd0,
    SEL_START  = 3'd1,
    SEL_SEGSZ  = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_ERRCLR = 3'd4,
    SEL_IENSET = 3'd5
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } seq_st_e;
endpackage

// File: rtl/iq_doorbell.sv
module iq_doorbell
  import iq_pkg::*;
#(
  parameter int W = DB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  input  logic         take,
  output logic [W-1:0] pending,
  output logic         ovf_hit
);
  localparam logic [W:0] TAKE_AMT = (W+1)'(CMD_BEATS);

  logic [W-1:0] cnt_q;
  logic [W:0]   grown;
  logic [W:0]   shrunk;

  always_comb begin
    grown  = {1'b0, cnt_q} + (add_en ? {1'b0, add_val} : '0);
    shrunk = grown - (take ? TAKE_AMT : '0);
  end

  assign ovf_hit = add_en & grown[W];
  assign pending = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= shrunk[W-1:0];
  end
endmodule

// File: rtl/iq_inflight.sv
module iq_inflight #(
  parameter int W   = 8,
  parameter int MAX = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         room
);
  logic [W-1:0] cnt_q;
  logic         dec_ok;

  assign dec_ok = dec & ((cnt_q != '0) | inc);
  assign count  = cnt_q;
  assign room   = cnt_q < W'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      case ({inc, dec_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             cfg_ok,
  input  logic [NERR-1:0]  err_set,
  output logic             q_enable,
  output logic             cont_err,
  output logic [IDX_W-1:0] seg_ncmd,
  output logic             start_load,
  output logic [NERR-1:0]  err_flags,
  output logic             irq
);
  logic             ena_q;
  logic             cont_q;
  logic [SEG_W-1:0] segsz_q;
  logic [NERR-1:0]  flags_q;
  logic [NERR-1:0]  ien_q;
  logic             ctrl_wr;
  logic             size_wr;
  logic [NERR-1:0]  clr_mask;
  logic [NERR-1:0]  ien_mask;

  assign ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);
  assign size_wr    = wr_en && (wr_sel == SEL_SEGSZ) && cfg_ok;
  assign start_load = wr_en && (wr_sel == SEL_START) && cfg_ok;
  assign clr_mask   = (wr_en && (wr_sel == SEL_ERRCLR)) ? wr_data[NERR-1:0] : '0;
  assign ien_mask   = (wr_en && (wr_sel == SEL_IENSET)) ? wr_data[NERR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q   <= 1'b0;
      cont_q  <= 1'b0;
      segsz_q <= '0;
      flags_q <= '0;
      ien_q   <= '0;
    end else begin
      if ((|err_set) && !cont_q) ena_q <= 1'b0;
      else if (ctrl_wr)          ena_q <= wr_data[0];
      if (ctrl_wr) cont_q <= wr_data[1];
      if (size_wr) segsz_q <= wr_data;
      flags_q <= (flags_q & ~clr_mask) | err_set;
      ien_q   <= ien_q | ien_mask;
    end
  end

  assign q_enable  = ena_q;
  assign cont_err  = cont_q;
  assign seg_ncmd  = segsz_q[SEG_W-1:BEAT_W];
  assign err_flags = flags_q;
  assign irq       = |(flags_q & ien_q);
endmodule

// File: rtl/iq_seq.sv
module iq_seq
  import iq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_enable,
  input  logic              have_cmd,
  input  logic              room,
  input  logic [IDX_W-1:0]  seg_ncmd,
  input  logic              start_load,
  input  logic [PTR_W-1:0]  start_ptr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_req_link,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_last,
  output logic              fetch_fire,
  output logic              rd_err,
  output logic              idle,
  output logic [ADDR_W-1:0] fetch_addr
);
  seq_st_e          st_q;
  logic             link_q;
  logic [PTR_W-1:0] base_q;
  logic [IDX_W-1:0] idx_q;
  logic [BEAT_W-1:0] beat_q;
  logic [PTR_W-1:0] line;
  logic             at_end;
  logic             rsp_acc;
  logic             last_beat;

  assign line       = base_q + {{(PTR_W-IDX_W){1'b0}}, idx_q};
  assign fetch_addr = {line, {LINE_LSB{1'b0}}};
  assign at_end     = idx_q >= seg_ncmd;
  assign last_beat  = beat_q == BEAT_W'(CMD_BEATS - 1);

  assign rd_req_valid = st_q == ST_REQ;
  assign rd_req_addr  = fetch_addr;
  assign rd_req_link  = link_q;
  assign rd_rsp_ready = (st_q == ST_DATA) && (link_q || cmd_ready);
  assign cmd_valid    = (st_q == ST_DATA) && !link_q && rd_rsp_valid;
  assign cmd_data     = rd_rsp_data;
  assign cmd_last     = last_beat;
  assign rsp_acc      = rd_rsp_valid && rd_rsp_ready;
  assign fetch_fire   = (st_q == ST_REQ) && rd_req_ready && !link_q;
  assign rd_err       = rsp_acc && rd_rsp_err;
  assign idle         = st_q == ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      link_q <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      beat_q <= '0;
    end else begin
      if (start_load) begin
        base_q <= start_ptr;
        idx_q  <= '0;
      end
      case (st_q)
        ST_IDLE: begin
          if (q_enable && have_cmd && (at_end || room)) begin
            st_q   <= ST_REQ;
            link_q <= at_end;
          end
        end
        ST_REQ: begin
          if (rd_req_ready) begin
            st_q   <= ST_DATA;
            beat_q <= '0;
          end
        end
        ST_DATA: begin
          if (rsp_acc) begin
            if (link_q) begin
              if (!rd_rsp_err) begin
                base_q <= rd_rsp_data[ADDR_W-1:LINE_LSB];
                idx_q  <= '0;
              end
              st_q <= ST_IDLE;
            end else begin
              beat_q <= beat_q + 1'b1;
              if (last_beat) begin
                idx_q <= idx_q + 1'b1;
                st_q  <= ST_IDLE;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iq_fetch_top.sv
module iq_fetch_top
  import iq_pkg::*;
#(
  parameter int MAX_INFLIGHT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_wr_sel,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_req_link,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_last,
  input  logic              done_pulse,
  input  logic              res_wr_err,
  output logic              q_enable,
  output logic [DB_W-1:0]   dbell_pending,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [INFL_W-1:0] inflight,
  output logic [NERR-1:0]   err_flags,
  output logic              irq
);
  localparam logic [DB_W-1:0] ONE_CMD = DB_W'(CMD_BEATS);

  logic             fetch_fire;
  logic             rd_err;
  logic             ovf_hit;
  logic             room;
  logic             seq_idle;
  logic             cfg_ok;
  logic             start_load;
  logic             cont_err_q;
  logic [IDX_W-1:0] seg_ncmd;
  logic [NERR-1:0]  err_set;

  assign cfg_ok = !q_enable && (inflight == '0) && seq_idle;

  always_comb begin
    err_set           = '0;
    err_set[ERR_RD]   = rd_err;
    err_set[ERR_WR]   = res_wr_err;
    err_set[ERR_DOVF] = ovf_hit;
  end

  iq_doorbell #(.W(DB_W)) u_dbell (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (cfg_wr_en && (cfg_wr_sel == SEL_DBELL)),
    .add_val (cfg_wr_data[DB_W-1:0]),
    .take    (fetch_fire),
    .pending (dbell_pending),
    .ovf_hit (ovf_hit)
  );

  iq_inflight #(.W(INFL_W), .MAX(MAX_INFLIGHT)) u_infl (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fetch_fire),
    .dec   (done_pulse),
    .count (inflight),
    .room  (room)
  );

  iq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_sel     (cfg_wr_sel),
    .wr_data    (cfg_wr_data[SEG_W-1:0]),
    .cfg_ok     (cfg_ok),
    .err_set    (err_set),
    .q_enable   (q_enable),
    .cont_err   (cont_err_q),
    .seg_ncmd   (seg_ncmd),
    .start_load (start_load),
    .err_flags  (err_flags),
    .irq        (irq)
  );

  iq_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_enable     (q_enable),
    .have_cmd     (dbell_pending >= ONE_CMD),
    .room         (room),
    .seg_ncmd     (seg_ncmd),
    .start_load   (start_load),
    .start_ptr    (cfg_wr_data[ADDR_W-1:LINE_LSB]),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_req_link  (rd_req_link),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .rd_rsp_err   (rd_rsp_err),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_data     (cmd_data),
    .cmd_last     (cmd_last),
    .fetch_fire   (fetch_fire),
    .rd_err       (rd_err),
    .idle         (seq_idle),
    .fetch_addr   (fetch_addr)
  );
endmodule

// File: rtl/iq_fetch_chk.sv
module iq_fetch_chk
  import iq_pkg::*;
#(
  parameter int MAX_INFLIGHT = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_req_link,
  input logic [INFL_W-1:0] inflight,
  input logic              q_enable,
  input logic              cont_err,
  input logic              res_wr_err,
  input logic [NERR-1:0]   err_flags,
  input logic              irq
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_link));

  // R6
  infl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= INFL_W'(MAX_INFLIGHT));

  // R6
  infl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (inflight == $past(inflight)) || (inflight == $past(inflight) + 1'b1)
             || (inflight == $past(inflight) - 1'b1));

  // R8
  err_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_err && !cont_err |=> !q_enable);

  // R8
  wr_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_err |=> err_flags[ERR_WR]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (err_flags != '0));
endmodule

bind iq_fetch_top iq_fetch_chk #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_req_link  (rd_req_link),
  .inflight     (inflight),
  .q_enable     (q_enable),
  .cont_err     (cont_err_q),
  .res_wr_err   (res_wr_err),
  .err_flags    (err_flags),
  .irq          (irq)
);

// File: tb/iq_fetch_top_tb.sv
module iq_fetch_top_tb;
  localparam int MAXI = 6;
  localparam int NCMD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_sel = '0;
  logic [48:0] cfg_wr_data = '0;
  logic        rd_req_valid, rd_req_link, rd_rsp_ready;
  logic        rd_req_ready = 1'b1;
  logic [48:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic        cmd_valid, cmd_last;
  logic        cmd_ready = 1'b0;
  logic [63:0] cmd_data;
  logic        done_pulse = 1'b0;
  logic        res_wr_err = 1'b0;
  logic        q_enable, irq;
  logic [19:0] dbell_pending;
  logic [48:0] fetch_addr;
  logic [7:0]  inflight;
  logic [2:0]  err_flags;

  int checks = 0;
  int errors = 0;
  bit inj_err = 1'b0;
  logic [63:0] exp_q[$];
  longint exp_base = 0;
  int exp_idx = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  iq_fetch_top #(.MAX_INFLIGHT(MAXI)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_link(rd_req_link), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .done_pulse(done_pulse), .res_wr_err(res_wr_err), .q_enable(q_enable),
    .dbell_pending(dbell_pending), .fetch_addr(fetch_addr), .inflight(inflight),
    .err_flags(err_flags), .irq(irq)
  );

  // Memory image: three segments of 17 words at bytes 0, 512, 1024, chained in a ring.
  function automatic logic [63:0] mem_word(longint byte_addr);
    longint w = byte_addr >> 3;
    longint seg = w / 64;
    if ((w % 64) == 16) return 64'(((seg + 1) % 3) * 512);
    return {8'hA5, 48'(byte_addr), 8'h3C};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] sel, logic [48:0] data);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 done_pulse = 1'b1;
    @(posedge clk); #1 done_pulse = 1'b0;
  endtask

  task automatic pulse_wr_err();
    @(posedge clk); #1 res_wr_err = 1'b1;
    @(posedge clk); #1 res_wr_err = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Driver: push the words of the next n commands, following the chain as the design must.
  task automatic push_cmds(int n);
    for (int c = 0; c < n; c++) begin
      if (exp_idx == NCMD) begin
        exp_base = longint'(mem_word(exp_base + 64 * NCMD));
        exp_idx = 0;
      end
      for (int b = 0; b < 8; b++) exp_q.push_back(mem_word(exp_base + 64 * exp_idx + 8 * b));
      exp_idx++;
    end
  endtask

  task automatic finish_run();
    chk(exp_q.size() == 0, "R4 all expected words seen", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_valid && rd_req_ready) begin
        automatic longint a = longint'(rd_req_addr);
        automatic bit lk = rd_req_link;
        automatic int nb = lk ? 1 : 8;
        for (int b = 0; b < nb; b++) begin
          @(posedge clk); #1;
          rd_rsp_valid = 1'b1;
          rd_rsp_data = mem_word(a + 8 * b);
          rd_rsp_err = inj_err && !lk;
          do @(negedge clk); while (!rd_rsp_ready);
        end
        @(posedge clk); #1;
        rd_rsp_valid = 1'b0;
        rd_rsp_err = 1'b0;
        if (!lk) inj_err = 1'b0;
      end
    end
  end

  // Back-pressure pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      cmd_ready = (cyc % 3) != 0;
    end
  end

  // Monitor / scoreboard
  initial begin
    int beat = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected command word", cmd_data, 64'd0);
        end else begin
          automatic logic [63:0] e = exp_q.pop_front();
          chk(cmd_data == e, "R4 R5 command word", cmd_data, e);
          chk(cmd_last == (beat == 7), "R4 last flag", 64'(cmd_last), 64'(beat == 7));
        end
        beat = (beat + 1) % 8;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dbell_pending == 0, "R10 pending", 64'(dbell_pending), 0);
    chk(inflight == 0, "R10 inflight", 64'(inflight), 0);
    chk(!q_enable && !irq && err_flags == 0, "R10 enable/irq/flags",
        64'({q_enable, irq, err_flags}), 0);
    chk(fetch_addr == 0 && !rd_req_valid && !cmd_valid, "R10 addr/valids",
        64'(fetch_addr), 0);

    cfg(3'd2, 49'd17);
    cfg(3'd1, 49'd0);
    cfg(3'd3, 49'd1);
    settle(1);
    chk(q_enable, "R9 enable set", 64'(q_enable), 1);

    // R1 R3: two commands inside the first segment
    push_cmds(2);
    cfg(3'd0, 49'd16);
    settle(80);
    chk(inflight == 2, "R6 inflight after two", 64'(inflight), 2);
    chk(dbell_pending == 0, "R1 pending drained", 64'(dbell_pending), 0);
    chk(fetch_addr == 128, "R3 next fetch address", 64'(fetch_addr), 128);

    // R5: cross two link words
    push_cmds(3);
    cfg(3'd0, 49'd24);
    settle(150);
    chk(inflight == 5, "R6 inflight after five", 64'(inflight), 5);
    chk(fetch_addr == 1088, "R5 address after chain", 64'(fetch_addr), 1088);

    // R3 R5: limit reached; link still read, next command waits
    push_cmds(2);
    cfg(3'd0, 49'd16);
    settle(80);
    chk(inflight == MAXI, "R3 inflight at limit", 64'(inflight), MAXI);
    chk(dbell_pending == 8, "R3 fetch held at limit", 64'(dbell_pending), 8);
    chk(fetch_addr == 0, "R5 chain wrapped to first segment", 64'(fetch_addr), 0);
    pulse_done();
    settle(60);
    chk(inflight == MAXI, "R6 done plus refill", 64'(inflight), MAXI);
    chk(dbell_pending == 0, "R1 pending after refill", 64'(dbell_pending), 0);
    chk(fetch_addr == 64, "R3 address after refill", 64'(fetch_addr), 64);

    // R6: drain and no underflow
    repeat (MAXI + 1) pulse_done();
    settle(2);
    chk(inflight == 0, "R6 no underflow", 64'(inflight), 0);

    // R7: start write ignored while enabled
    cfg(3'd1, 49'd512);
    settle(2);
    chk(fetch_addr == 64, "R7 start ignored while enabled", 64'(fetch_addr), 64);

    // R8 R9: result-write error without continue-on-error
    pulse_wr_err();
    settle(1);
    chk(!q_enable, "R8 enable cleared", 64'(q_enable), 0);
    chk(err_flags == 3'b010, "R8 write error flag", 64'(err_flags), 2);
    chk(!irq, "R9 irq masked", 64'(irq), 0);
    cfg(3'd5, 49'd2);
    settle(1);
    chk(irq, "R9 irq enabled", 64'(irq), 1);
    cfg(3'd4, 49'd2);
    settle(1);
    chk(err_flags == 0 && !irq, "R9 flag cleared", 64'({irq, err_flags}), 0);

    // R7: start write accepted when quiescent
    cfg(3'd1, 49'd512);
    settle(1);
    chk(fetch_addr == 512, "R7 start accepted", 64'(fetch_addr), 512);
    exp_base = 512;
    exp_idx = 0;

    // R8: continue-on-error keeps the enable
    cfg(3'd3, 49'd3);
    pulse_wr_err();
    settle(1);
    chk(q_enable, "R8 continue keeps enable", 64'(q_enable), 1);
    chk(err_flags == 3'b010, "R8 flag with continue", 64'(err_flags), 2);
    cfg(3'd4, 49'd7);

    // R8: read error stops the queue after the current command
    cfg(3'd3, 49'd1);
    inj_err = 1'b1;
    push_cmds(1);
    cfg(3'd0, 49'd16);
    settle(80);
    chk(!q_enable, "R8 read error disables", 64'(q_enable), 0);
    chk(err_flags == 3'b001, "R8 read error flag", 64'(err_flags), 1);
    chk(dbell_pending == 8, "R8 second command not fetched", 64'(dbell_pending), 8);
    chk(inflight == 1, "R6 one in flight", 64'(inflight), 1);
    chk(fetch_addr == 576, "R3 address after error", 64'(fetch_addr), 576);
    cfg(3'd4, 49'd7);

    // R2: doorbell overflow
    cfg(3'd0, 49'hFFFF8);
    settle(1);
    chk(dbell_pending == 0, "R2 count wraps", 64'(dbell_pending), 0);
    chk(err_flags == 3'b100, "R2 overflow flag", 64'(err_flags), 4);
    cfg(3'd5, 49'd4);
    settle(1);
    chk(irq, "R9 overflow irq", 64'(irq), 1);

    finish_run();
  end
endmodule